// File: doc/BRIEF.md
# Write-Batching Bus Turnaround Controller

This block sits between two request streams and a single bidirectional data bus. Read requests go straight to the command output when the bus is facing the read direction. Write requests are parked in an internal buffer and leave it in batches, so the bus changes direction as seldom as possible. Each change of direction costs a fixed number of idle cycles in which no command goes out.

Batching uses hysteresis on buffer occupancy. Once the buffer holds the upper threshold of entries, the block enters a drain state, refuses reads and sends buffered writes back to back. It stays in that state until occupancy has come down to the lower threshold. Outside the drain state reads always win, and a buffered write only goes out in a cycle with no read waiting. A full buffer refuses further writes. Since the upper threshold never exceeds the depth, a full buffer is always draining, whatever reads are pending.

Top module: `wdrain_ctrl`

## Requirements
- R1: After reset the command output is idle, `wr_ready` is 1, the bus faces the read direction and no turnaround is pending, so a read offered in the first cycle after reset is accepted in that cycle.
- R2: `wr_ready` is 0 exactly when the buffer holds `DEPTH` entries. A write is stored in every cycle in which `wr_valid` and `wr_ready` are both 1.
- R3: A read is accepted in a cycle with `rd_valid` and `rd_ready` both 1. In the next cycle `cmd_valid` is 1, `cmd_is_wr` is 0 (0 means read, 1 means write), `cmd_addr` equals the accepted `rd_addr` and `cmd_data` is zero.
- R4: Outside the drain state, no write command is issued in any cycle in which `rd_valid` is 1.
- R5: In the cycle after the push that brings occupancy to `HI_MARK`, the block is draining and `rd_ready` stays 0 even with `rd_valid` held at 1. One push earlier, with occupancy `HI_MARK`-1, reads are still accepted.
- R6: Draining stops when occupancy reaches `LO_MARK`. With reads held pending throughout, exactly `HI_MARK`-`LO_MARK` writes are issued, and after that reads are served again.
- R7: Between two consecutive commands of opposite direction at least `TURN_CYC` cycles pass with `cmd_valid` at 0. If the new-direction request is already waiting when the last command of the old direction is issued, exactly `TURN_CYC` idle cycles pass.
- R8: Writes leave in the order they were accepted. Each write command carries the address and data that were accepted with it on `cmd_addr` and `cmd_data`, with `cmd_is_wr` at 1.
- R9: A write offered while `wr_ready` is 0 is dropped and never appears on the command output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_valid | input | 1 | A read request is offered |
| rd_addr | input | ADDR_W | Address of the offered read |
| rd_ready | output | 1 | The offered read is taken this cycle |
| wr_valid | input | 1 | A write request is offered |
| wr_addr | input | ADDR_W | Address of the offered write |
| wr_data | input | DATA_W | Data of the offered write |
| wr_ready | output | 1 | The write buffer has room |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_is_wr | output | 1 | Command direction: 1 write, 0 read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_data | output | DATA_W | Write data, zero for reads |

## Verification
`rd_ready` and `wr_ready` are combinational, so they are valid in the same cycle as the offer. A taken read shows up on the command port one cycle after its handshake. A buffered write needs one cycle in the buffer plus `TURN_CYC` turnaround cycles before its issue cycle, and one more cycle before it appears. The drain state takes effect in the cycle after the push that reaches the upper threshold. The bench drives inputs on the falling edge and samples the ready signals shortly after that. A monitor stamps every command with the index of the rising edge that produced it, so ordering, latency and turnaround gaps are checked as exact stamp differences rather than by waiting on events.

// File: rtl/wdrain_pkg.sv
// Shared types for the write-batching bus controller.
package wdrain_pkg;

    // Direction the shared data bus is currently facing.
    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } bus_dir_e;

endpackage

// File: rtl/wdrain_fifo.sv
// Write buffer: circular FIFO holding {address, data} of pending writes.
// Assumes the caller never pushes when full nor pops when empty.
// The head entry is readable combinationally; storage is not reset.
module wdrain_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 48,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    // Store incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers with wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_data = mem[rd_ptr];
    assign count     = cnt_q;
    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);

    // Occupancy never exceeds the depth.
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // The arbiter only takes writes that exist.
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/wdrain_mode.sv
// Drain-state tracker with hysteresis between two occupancy thresholds.
// Enters draining when the next occupancy reaches HI_MARK and leaves
// when it falls to LO_MARK. Assumes LO_MARK < HI_MARK <= DEPTH.
module wdrain_mode #(
    parameter int DEPTH   = 8,
    parameter int HI_MARK = 6,
    parameter int LO_MARK = 2,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          push,
    input  logic          pop,
    output logic          drain
);
    localparam logic [CW:0] HI_V = (CW+1)'(HI_MARK);
    localparam logic [CW:0] LO_V = (CW+1)'(LO_MARK);

    logic [CW:0] cnt_next;
    logic        drain_d;

    // Predict next occupancy so the state lines up with the count register.
    always_comb begin
        cnt_next = {1'b0, count} + (CW+1)'(push) - (CW+1)'(pop);
        drain_d  = drain ? (cnt_next > LO_V) : (cnt_next >= HI_V);
    end

    // Hold the drain state.
    always_ff @(posedge clk) begin
        if (!rst_n) drain <= 1'b0;
        else        drain <= drain_d;
    end

    // At or above the upper threshold the block is always draining.
    p_drain_at_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= CW'(HI_MARK)) |-> drain);

    // While draining, occupancy stays above the lower threshold.
    p_drain_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drain |-> (count > CW'(LO_MARK)));

    // Draining ends exactly at the lower threshold.
    p_drain_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drain) |-> (count == CW'(LO_MARK)));

endmodule

// File: rtl/wdrain_arb.sv
// Direction arbiter: picks read or write for the bus, owns its direction
// and inserts TURN_CYC idle cycles on every reversal (the reversal cycle
// counts as the first). Assumes TURN_CYC >= 1.
module wdrain_arb
    import wdrain_pkg::*;
#(
    parameter int TURN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_valid,
    input  logic drain,
    input  logic wq_nonempty,
    output logic issue_rd,
    output logic issue_wr
);
    localparam int TCW = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1;
    localparam logic [TCW-1:0] TLOAD = TCW'(TURN_CYC - 1);

    bus_dir_e       dir_q;
    logic [TCW-1:0] tcnt_q;
    logic           want_rd, want_wr, settled, flip;

    // Decide what each direction wants and whether the bus may reverse.
    always_comb begin
        want_rd  = rd_valid && !drain;
        want_wr  = wq_nonempty && (drain || !rd_valid);
        settled  = (tcnt_q == '0);
        issue_rd = settled && (dir_q == DIR_RD) && want_rd;
        issue_wr = settled && (dir_q == DIR_WR) && want_wr;
        flip     = settled && ((dir_q == DIR_RD) ? want_wr : want_rd);
    end

    // Reverse the bus and run the turnaround countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= DIR_RD;
            tcnt_q <= '0;
        end else if (flip) begin
            dir_q  <= (dir_q == DIR_RD) ? DIR_WR : DIR_RD;
            tcnt_q <= TLOAD;
        end else if (!settled) begin
            tcnt_q <= tcnt_q - 1'b1;
        end
    end

    // Outside draining, a pending read blocks every write.
    p_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !drain) |-> !issue_wr);

    // No read goes out while draining.
    p_drain_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drain |-> !issue_rd);

endmodule

// File: rtl/wdrain_ctrl.sv
// Top of the write-batching bus controller. Reads pass through when the
// bus faces them; writes are buffered and issued in batches driven by
// occupancy hysteresis. Commands are registered: a command issued in
// cycle t is presented on the cmd_* outputs in cycle t+1.
// Assumes LO_MARK < HI_MARK <= DEPTH and TURN_CYC >= 1.
module wdrain_ctrl #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 8,
    parameter int HI_MARK  = 6,
    parameter int LO_MARK  = 2,
    parameter int TURN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              cmd_valid,
    output logic              cmd_is_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    localparam int EW = ADDR_W + DATA_W;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int GW = $clog2(TURN_CYC + 2);

    logic [EW-1:0] head;
    logic [CW-1:0] wq_count;
    logic          wq_full, wq_empty, push, pop, drain, issue_rd, issue_wr;

    assign wr_ready = !wq_full;
    assign push     = wr_valid && !wq_full;
    assign rd_ready = issue_rd;
    assign pop      = issue_wr;

    wdrain_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({wr_addr, wr_data}),
        .pop       (pop),
        .head_data (head),
        .count     (wq_count),
        .full      (wq_full),
        .empty     (wq_empty)
    );

    wdrain_mode #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .count (wq_count),
        .push  (push),
        .pop   (pop),
        .drain (drain)
    );

    wdrain_arb #(.TURN_CYC(TURN_CYC)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_valid    (rd_valid),
        .drain       (drain),
        .wq_nonempty (!wq_empty),
        .issue_rd    (issue_rd),
        .issue_wr    (issue_wr)
    );

    // Register the chosen command onto the bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_is_wr <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= issue_rd || issue_wr;
            cmd_is_wr <= issue_wr;
            cmd_addr  <= issue_wr ? head[EW-1:DATA_W] : rd_addr;
            cmd_data  <= issue_wr ? head[DATA_W-1:0] : '0;
        end
    end

    // Assertion support: idle cycles since the last command and its direction.
    logic [GW-1:0] gap_q;
    logic          seen_q, last_wr_q;

    // Count idle output cycles, saturating at TURN_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= '0;
            seen_q    <= 1'b0;
            last_wr_q <= 1'b0;
        end else if (cmd_valid) begin
            gap_q     <= '0;
            seen_q    <= 1'b1;
            last_wr_q <= cmd_is_wr;
        end else if (gap_q < GW'(TURN_CYC)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // A direction change on the bus follows at least TURN_CYC idle cycles.
    p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && seen_q && (cmd_is_wr != last_wr_q)) |-> (gap_q >= GW'(TURN_CYC)));

    // A taken read appears on the bus in the next cycle with its address.
    p_read_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> (cmd_valid && !cmd_is_wr && cmd_addr == $past(rd_addr)));

    // A refused write never raises occupancy.
    p_full_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> (wq_count <= $past(wq_count)));

endmodule

// File: tb/wdrain_ctrl_tb.sv
// Directed bench for wdrain_ctrl: one task per scenario, each checks itself.
module wdrain_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int HI   = 6;
    localparam int LO   = 2;
    localparam int TURN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_ready;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready;
    logic          cmd_valid, cmd_is_wr;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    // Command log filled by the monitor.
    int          n_log = 0;
    bit          lg_wr   [512];
    int unsigned lg_addr [512];
    int unsigned lg_data [512];
    int          lg_cyc  [512];

    wdrain_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(8), .HI_MARK(HI),
                  .LO_MARK(LO), .TURN_CYC(TURN)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: stamp each command with the index of the edge that made it.
    always begin
        @(posedge clk);
        #1;
        if (rst_n && cmd_valid && n_log < 512) begin
            lg_wr[n_log]   = cmd_is_wr;
            lg_addr[n_log] = 32'(cmd_addr);
            lg_data[n_log] = cmd_data;
            lg_cyc[n_log]  = cyc;
            n_log++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset state and a read accepted at once.
    task automatic t_reset();
        int acc;
        chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
        chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);
        chk(rd_ready == 1'b0, "R1", "rd_ready with no read", rd_ready, 0);
        rd_valid = 1'b1; rd_addr = 16'h1111;
        #1;
        chk(rd_ready == 1'b1, "R1", "first read taken without turnaround", rd_ready, 1);
        acc = cyc;
        @(negedge clk); rd_valid = 1'b0;
        idle(2);
        chk(n_log == 1 && lg_cyc[0] == acc + 1, "R3", "first read stamp", lg_cyc[0], acc + 1);
        chk(lg_addr[0] == 32'h1111 && !lg_wr[0], "R3", "first read addr", lg_addr[0], 32'h1111);
    endtask

    // R3: back-to-back reads pass through one cycle after handshake.
    task automatic t_reads();
        int base = n_log;
        int acc [3];
        for (int i = 0; i < 3; i++) begin
            rd_valid = 1'b1; rd_addr = AW'(16'h2000 + i);
            #1;
            chk(rd_ready == 1'b1, "R3", "read accepted", rd_ready, 1);
            acc[i] = cyc;
            @(negedge clk);
        end
        rd_valid = 1'b0;
        idle(3);
        chk(n_log - base == 3, "R3", "read count", n_log - base, 3);
        for (int i = 0; i < 3; i++) begin
            chk(!lg_wr[base+i] && lg_addr[base+i] == 32'h2000 + i && lg_data[base+i] == 0,
                "R3", "read fields", lg_addr[base+i], 32'h2000 + i);
            chk(lg_cyc[base+i] == acc[i] + 1, "R3", "read latency", lg_cyc[base+i], acc[i] + 1);
        end
    endtask

    // R4, R7, R8: a buffered write waits behind reads, then turns the bus.
    task automatic t_priority();
        int base = n_log;
        int last_acc = 0;
        int wpos = -1;
        rd_valid = 1'b1; rd_addr = 16'h3000;
        wr_valid = 1'b1; wr_addr = 16'h0400; wr_data = 32'hCAFE0001;
        #1;
        chk(wr_ready == 1'b1, "R2", "write accepted", wr_ready, 1);
        @(negedge clk); wr_valid = 1'b0;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk(rd_ready == 1'b1, "R4", "read wins over buffered write", rd_ready, 1);
            last_acc = cyc;
            @(negedge clk);
        end
        rd_valid = 1'b0;
        idle(12);
        for (int i = base; i < n_log; i++) if (lg_wr[i]) wpos = i;
        chk(wpos >= 0, "R8", "write issued", wpos, 0);
        if (wpos >= 0) begin
            chk(lg_cyc[wpos] > last_acc + 1, "R4", "write after last read", lg_cyc[wpos], last_acc + 2);
            chk(lg_cyc[wpos] == last_acc + 1 + TURN + 1, "R7", "exact turnaround",
                lg_cyc[wpos], last_acc + 2 + TURN);
            chk(lg_addr[wpos] == 32'h0400 && lg_data[wpos] == 32'hCAFE0001, "R8",
                "write fields", lg_data[wpos], 32'hCAFE0001);
        end
    endtask

    // R5, R6, R8: enter drain at HI with reads pending, leave at LO.
    task automatic t_drain();
        int base;
        int nw = 0;
        rd_valid = 1'b1; rd_addr = 16'h5000;
        idle(6);
        base = n_log;
        for (int i = 0; i < HI; i++) begin
            wr_valid = 1'b1; wr_addr = AW'(16'h0100 + i); wr_data = 32'hD000 + i;
            #1;
            chk(wr_ready == 1'b1, "R2", "drain push accepted", wr_ready, 1);
            if (i == HI - 1)
                chk(rd_ready == 1'b1, "R5", "read still taken at HI-1", rd_ready, 1);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        #1;
        chk(rd_ready == 1'b0, "R5", "reads refused once draining", rd_ready, 0);
        idle(25);
        #1;
        chk(rd_ready == 1'b1, "R6", "reads served after drain", rd_ready, 1);
        for (int i = base; i < n_log; i++) if (lg_wr[i]) begin
            if (nw < HI)
                chk(lg_data[i] == 32'hD000 + nw && lg_addr[i] == 32'h0100 + nw, "R8",
                    "drain order", lg_data[i], 32'hD000 + nw);
            nw++;
        end
        chk(nw == HI - LO, "R6", "writes issued in drain", nw, HI - LO);
        @(negedge clk); rd_valid = 1'b0;
        idle(15);
        nw = 0;
        for (int i = base; i < n_log; i++) if (lg_wr[i]) begin
            if (nw < HI)
                chk(lg_data[i] == 32'hD000 + nw, "R8", "remaining order", lg_data[i], 32'hD000 + nw);
            nw++;
        end
        chk(nw == HI, "R8", "all writes issued", nw, HI);
    endtask

    // R2, R9: fill the buffer; an offer while full is dropped.
    task automatic t_full();
        int base;
        int nw = 0;
        rd_valid = 1'b1; rd_addr = 16'h6000;
        idle(6);
        base = n_log;
        for (int i = 0; i < 9; i++) begin
            wr_valid = 1'b1; wr_addr = AW'(16'h0200 + i); wr_data = 32'hF000 + i;
            #1;
            chk(wr_ready == (i < 8), "R2", "wr_ready while filling", wr_ready, (i < 8));
            @(negedge clk);
        end
        wr_valid = 1'b0; rd_valid = 1'b0;
        idle(30);
        for (int i = base; i < n_log; i++) if (lg_wr[i]) begin
            if (nw < 8)
                chk(lg_data[i] == 32'hF000 + nw, "R9", "stored order", lg_data[i], 32'hF000 + nw);
            nw++;
        end
        chk(nw == 8, "R9", "refused write dropped", nw, 8);
        chk(wr_ready == 1'b1, "R2", "wr_ready after empty", wr_ready, 1);
    endtask

    // R7: every reversal in the whole log keeps the turnaround gap.
    task automatic t_gaps();
        for (int i = 1; i < n_log; i++)
            if (lg_wr[i] != lg_wr[i-1])
                chk(lg_cyc[i] - lg_cyc[i-1] >= TURN + 1, "R7", "reversal gap",
                    lg_cyc[i] - lg_cyc[i-1], TURN + 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        t_reset();
        t_reads();
        t_priority();
        t_drain();
        t_full();
        t_gaps();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule